// File: doc/BRIEF.md
# Quasi-Bidirectional Pin Drive Control

This block decides, for every pin of a 48-pin quasi-bidirectional port, which of three pad drivers is switched on. The three drivers are a strong pull-low, a weak pull-up and a short strong boost pull-up. The port has no direction register. A pin driven to 0 is an output low. A pin written to 1 rests on the weak pull-up, so an outside device can pull it down and the pin can be read as an input. Changing a pin between input and output use is done only by writing its latch.

The serial bus controller updates the output latch one byte at a time. It presents the byte on `latch_d` and pulses the matching bit of `latch_upd` once that byte has been acknowledged. Each bit that goes from 0 to 1 in that write turns on the boost pull-up, which gives the pin a fast rising edge on a heavily loaded line. The boost stays on until the next falling edge of the bus clock, which arrives as the single-cycle pulse `scl_fall`. A small two-state machine per byte tracks whether a boost is active. The pin levels come back through a two-flop synchroniser before the bus controller and the interrupt logic use them.

Each per-byte machine has two states:
- `BST_IDLE`: no boost is active.
- `BST_ACTIVE`: a boost is active.

Its transitions are:
- From `BST_IDLE` to `BST_ACTIVE`: on a write with at least one rising bit.
- From `BST_ACTIVE`, on a write: to `BST_ACTIVE` if the write has a rising bit, otherwise to `BST_IDLE`.
- From `BST_ACTIVE` to `BST_IDLE`: on `scl_fall` when there is no write to that byte.

Top module: `qbd_pin_ctl`

## Requirements
- R1: After reset, every latch bit is 1. The weak pull-up is on for all pins, and the strong pull-low and boost are off for all pins. `pin_sync` reads all ones.
- R2: When `latch_upd[b]` is sampled high on a clock edge, bits `latch_d[8b+7:8b]` are stored for pins 8b+7..8b. From that edge, every stored 0 drives `pull_low_en` high and `weak_pu_en` low for that pin.
- R3: Every stored 1 drives `weak_pu_en` high and `pull_low_en` low for that pin. A pin never has both enables on at once.
- R4: A write to byte b sets `boost_pu_en` only on the pins of byte b whose stored bit goes from 0 to 1. The boost is visible from the edge that samples the strobe.
- R5: A `scl_fall` pulse sampled with no write to byte b clears all boost enables of byte b at that edge.
- R6: Without a write or a `scl_fall`, the boost enables of a byte keep their value.
- R7: If a write to byte b and `scl_fall` are sampled on the same edge, the write wins: the boost of byte b becomes the new set of rising bits.
- R8: `pull_low_en` and `boost_pu_en` are never both high for the same pin.
- R9: Bytes whose `latch_upd` bit is low ignore `latch_d`. Their pull-low and weak enables do not change.
- R10: `pin_sync` equals the value `pin_in` had two clock edges earlier.
- R11: Writing 1 over a stored 1 starts no boost, and a write with no rising bit ends an active boost in that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| latch_d | input | 48 | New latch value; byte b sits in bits 8b+7..8b |
| latch_upd | input | 6 | Per-byte store strobe, one bit per byte |
| scl_fall | input | 1 | Single-cycle pulse on each synchronised bus-clock falling edge |
| pin_in | input | 48 | Raw pin levels from the pads |
| pull_low_en | output | 48 | Strong pull-low enable per pin |
| weak_pu_en | output | 48 | Weak pull-up enable per pin |
| boost_pu_en | output | 48 | Transient strong pull-up enable per pin |
| pin_sync | output | 48 | Pin levels after two synchroniser flops |

## Verification
The assertions take four things for granted about the inputs:
- `latch_upd`, `latch_d` and `scl_fall` are already synchronous to `clk`.
- `scl_fall` is a clean pulse from an upstream edge detector.
- `pin_in` may be asynchronous and is checked only after the two-flop delay.
- The readback is compared only once two edges have passed since reset.

The stimulus respects these points. It changes every input only on the falling clock edge, holds `latch_upd` and `scl_fall` for exactly one cycle, and updates `pin_in` at the same safe point. This keeps every sampled value stable at the rising edge.

// File: rtl/qbd_pkg.sv
package qbd_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        BST_IDLE   = 1'b0,
        BST_ACTIVE = 1'b1
    } boost_state_e;
endpackage

// File: rtl/qbd_sync.sv
module qbd_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '1;
            stage2_q <= '1;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/qbd_byte_ctl.sv
module qbd_byte_ctl
    import qbd_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [W-1:0] d,
    input  logic         scl_fall,
    output logic [W-1:0] pull_low,
    output logic [W-1:0] weak_pu,
    output logic [W-1:0] boost
);
    boost_state_e st_q, st_d;
    logic [W-1:0] latch_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] rise;

    assign rise = d & ~latch_q;

    // next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BST_IDLE: begin
                if (upd && (|rise)) st_d = BST_ACTIVE;
            end
            BST_ACTIVE: begin
                if (upd)           st_d = (|rise) ? BST_ACTIVE : BST_IDLE;
                else if (scl_fall) st_d = BST_IDLE;
            end
            default: st_d = BST_IDLE;
        endcase
    end

    // state register with latch and boost mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= BST_IDLE;
            latch_q <= '1;
            mask_q  <= '0;
        end else begin
            st_q <= st_d;
            if (upd) begin
                latch_q <= d;
                mask_q  <= rise;
            end else if (scl_fall) begin
                mask_q  <= '0;
            end
        end
    end

    // output decode
    always_comb begin
        pull_low = ~latch_q;
        weak_pu  = latch_q;
        boost    = (st_q == BST_ACTIVE) ? mask_q : '0;
    end
endmodule

// File: rtl/qbd_pin_ctl.sv
module qbd_pin_ctl
    import qbd_pkg::*;
#(
    parameter int NUM_BYTES = 6,
    parameter int LANE_W    = BYTE_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BYTES*LANE_W-1:0]   latch_d,
    input  logic [NUM_BYTES-1:0]          latch_upd,
    input  logic                          scl_fall,
    input  logic [NUM_BYTES*LANE_W-1:0]   pin_in,
    output logic [NUM_BYTES*LANE_W-1:0]   pull_low_en,
    output logic [NUM_BYTES*LANE_W-1:0]   weak_pu_en,
    output logic [NUM_BYTES*LANE_W-1:0]   boost_pu_en,
    output logic [NUM_BYTES*LANE_W-1:0]   pin_sync
);
    localparam int PINS = NUM_BYTES * LANE_W;

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        qbd_byte_ctl #(.W(LANE_W)) i_byte (
            .clk      (clk),
            .rst_n    (rst_n),
            .upd      (latch_upd[b]),
            .d        (latch_d[b*LANE_W +: LANE_W]),
            .scl_fall (scl_fall),
            .pull_low (pull_low_en[b*LANE_W +: LANE_W]),
            .weak_pu  (weak_pu_en[b*LANE_W +: LANE_W]),
            .boost    (boost_pu_en[b*LANE_W +: LANE_W])
        );
    end

    qbd_sync #(.W(PINS)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );
endmodule

// File: rtl/qbd_pin_ctl_chk.sv
module qbd_pin_ctl_chk #(
    parameter int NUM_BYTES = 6,
    parameter int LANE_W    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_BYTES*LANE_W-1:0] latch_d,
    input logic [NUM_BYTES-1:0]        latch_upd,
    input logic                        scl_fall,
    input logic [NUM_BYTES*LANE_W-1:0] pin_in,
    input logic [NUM_BYTES*LANE_W-1:0] pull_low_en,
    input logic [NUM_BYTES*LANE_W-1:0] weak_pu_en,
    input logic [NUM_BYTES*LANE_W-1:0] boost_pu_en,
    input logic [NUM_BYTES*LANE_W-1:0] pin_sync
);
    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_low_en & boost_pu_en) == '0); // R8

    AST_WEAK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_low_en & weak_pu_en) == '0); // R3

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (pin_sync == $past(pin_in, 2))); // R10

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_chk
        AST_BOOST_END: assert property (@(posedge clk) disable iff (!rst_n)
            (scl_fall && !latch_upd[b]) |=> (boost_pu_en[b*LANE_W +: LANE_W] == '0)); // R5

        AST_BOOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!scl_fall && !latch_upd[b]) |=> $stable(boost_pu_en[b*LANE_W +: LANE_W])); // R6

        AST_BOOST_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            latch_upd[b] |=> (boost_pu_en[b*LANE_W +: LANE_W] ==
                ($past(latch_d[b*LANE_W +: LANE_W]) & ~$past(weak_pu_en[b*LANE_W +: LANE_W])))); // R4

        AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !latch_upd[b] |=> $stable(pull_low_en[b*LANE_W +: LANE_W])); // R9
    end
endmodule

bind qbd_pin_ctl qbd_pin_ctl_chk #(.NUM_BYTES(NUM_BYTES), .LANE_W(LANE_W)) i_chk (.*);

// File: tb/test_qbd_pin_ctl.sv
module test_qbd_pin_ctl;
    localparam int NB = 6;
    localparam int P  = NB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [P-1:0]  latch_d = '0;
    logic [NB-1:0] latch_upd = '0;
    logic          scl_fall = 1'b0;
    logic [P-1:0]  pin_in = '1;
    logic [P-1:0]  pull_low_en, weak_pu_en, boost_pu_en, pin_sync;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [P-1:0] m_latch = '1;
    logic [P-1:0] m_boost = '0;

    always #5 clk = ~clk;

    qbd_pin_ctl i_qbd_pin_ctl (
        .clk(clk), .rst_n(rst_n), .latch_d(latch_d), .latch_upd(latch_upd),
        .scl_fall(scl_fall), .pin_in(pin_in), .pull_low_en(pull_low_en),
        .weak_pu_en(weak_pu_en), .boost_pu_en(boost_pu_en), .pin_sync(pin_sync)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [P-1:0] act, input logic [P-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " pull_low"}, pull_low_en, ~m_latch);
        chk({tag, " weak"},     weak_pu_en,  m_latch);
        chk({tag, " boost"},    boost_pu_en, m_boost);
        chk({tag, " R8 no fight"}, pull_low_en & boost_pu_en, '0);
    endtask

    // one cycle of stimulus at a falling edge, model update, check at next falling edge
    task automatic step(input logic [NB-1:0] upd, input logic [P-1:0] d, input logic scl, input string tag);
        latch_upd = upd;
        latch_d   = d;
        scl_fall  = scl;
        @(negedge clk);
        latch_upd = '0;
        scl_fall  = 1'b0;
        latch_d   = ~d;
        for (int b = 0; b < NB; b++) begin
            if (upd[b]) begin
                m_boost[b*8 +: 8] = d[b*8 +: 8] & ~m_latch[b*8 +: 8];
                m_latch[b*8 +: 8] = d[b*8 +: 8];
            end else if (scl) begin
                m_boost[b*8 +: 8] = '0;
            end
        end
        chk_all(tag);
    endtask

    task automatic t_reset;
        chk_all("R1 reset");
        chk("R1 pin_sync", pin_sync, '1);
    endtask

    task automatic t_write_low;
        step(6'b000001, '0, 1'b0, "R2 R9 write byte0 zero");
    endtask

    task automatic t_rise_and_end;
        step(6'b000001, 48'h0000_0000_00A5, 1'b0, "R3 R4 rise byte0");
        chk("R4 boost value", boost_pu_en, 48'h0000_0000_00A5);
        step('0, '0, 1'b0, "R6 hold 1");
        step('0, '0, 1'b0, "R6 hold 2");
        chk("R6 boost kept", boost_pu_en, 48'h0000_0000_00A5);
        step('0, '0, 1'b1, "R5 scl fall");
        chk("R5 boost cleared", boost_pu_en, '0);
    endtask

    task automatic t_no_reboost;
        step(6'b000001, 48'h0000_0000_00FF, 1'b0, "R4 partial rise");
        chk("R4 only rising", boost_pu_en, 48'h0000_0000_005A);
        step(6'b000001, 48'h0000_0000_00FF, 1'b0, "R11 rewrite ones");
        chk("R11 boost ended", boost_pu_en, '0);
    endtask

    task automatic t_collision;
        step(6'b000010, '0, 1'b0, "R2 byte1 low");
        step(6'b000010, 48'h0000_0000_0F00, 1'b1, "R7 write with scl");
        chk("R7 write wins", boost_pu_en, 48'h0000_0000_0F00);
        step('0, '0, 1'b1, "R5 scl after collision");
    endtask

    task automatic t_multi_byte;
        step(6'b000100, 48'h0000_003C_0000, 1'b0, "R11 no rise from ones");
        chk("R11 no boost", boost_pu_en, '0);
        step(6'b100100, 48'h0000_00FF_0000, 1'b0, "R4 R9 two bytes");
        chk("R4 byte2 only", boost_pu_en, 48'h0000_00C3_0000);
        step('0, 48'h1234_5678_9ABC, 1'b0, "R9 ignore data");
        step('0, '0, 1'b1, "R5 clear all");
    endtask

    task automatic t_sync;
        pin_in = 48'h1357_9BDF_2468;
        @(negedge clk);
        chk("R10 one edge", pin_sync, '1);
        @(negedge clk);
        chk("R10 two edges", pin_sync, 48'h1357_9BDF_2468);
        pin_in = 48'hF0F0_0F0F_AAAA;
        @(negedge clk);
        chk("R10 old kept", pin_sync, 48'h1357_9BDF_2468);
        @(negedge clk);
        chk("R10 new value", pin_sync, 48'hF0F0_0F0F_AAAA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_low();
        t_rise_and_end();
        t_no_reboost();
        t_collision();
        t_multi_byte();
        t_sync();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule